// File: doc/BRIEF.md
# Programmable Complementary Deadtime Inserter

The block turns one PWM command into a pair of complementary gate commands, one for the high-side switch and one for the low-side switch of a half-bridge. Whenever the command changes level, the side that is on is switched off at once. The opposite side is switched on only after a programmable number of clock ticks during which both outputs are low. This break-before-make gap is applied at every transition.

The turn-on of the high side and the turn-on of the low side each have their own gap setting, since the two directions usually need different spacing. Each setting is a plain tick count with one-clock resolution. Values below a fixed floor, including zero, are raised to that floor. Values above a fixed ceiling are lowered to the ceiling and never wrap. A status output is high while either setting is being limited.

A setting is read only when a gap starts. If the command reverses while a gap is still being timed, both outputs stay low and the gap is timed again from the beginning, using the setting for the new direction.

Top module: `dtgap_inserter`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle.
- R2: When a changed `pwm_cmd` is sampled at a clock edge, the side that was on goes low after that edge. The opposite side goes high exactly G cycles later, where G is the limited setting for that direction, so both outputs are low for exactly G cycles.
- R3: A high-side turn-on (`pwm_cmd` = 1) times its gap from `dt_lh_cfg`. A low-side turn-on (`pwm_cmd` = 0) times its gap from `dt_hl_cfg`.
- R4: The gap has one-clock resolution. A setting S with DT_LO <= S <= DT_HI gives a gap of S cycles, so raising the setting by one lengthens the gap by one cycle and never shortens it.
- R5: A setting below DT_LO (default 2), including 0, gives a gap of DT_LO cycles. A setting above DT_HI (default 40), up to 255, gives a gap of DT_HI cycles.
- R6: `clamp_active` is high in the same cycle whenever either setting lies outside [DT_LO, DT_HI], and low otherwise.
- R7: While `rst` is high, both outputs are low. After `rst` falls, the side selected by `pwm_cmd` turns on only after the full gap for its direction, counted as in R2 from the first edge that has `rst` low.
- R8: A setting is read only at the edge that starts a gap. Changing it while the gap is being timed does not change that gap.
- R9: If `pwm_cmd` reverses during a gap, both outputs stay low. A fresh gap with the new direction's setting starts at the edge that samples the reversal.
- R10: While `pwm_cmd` stays at the level of the side that is on, that side stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| dt_lh_cfg | input | CFG_W | Gap setting in ticks for a high-side turn-on |
| dt_hl_cfg | input | CFG_W | Gap setting in ticks for a low-side turn-on |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| clamp_active | output | 1 | High while either setting is being limited |

## Verification
Suppose the bench drives a new command level in the cycle numbered n. The side that was on is then due low in cycle n+1, and the other side is due high in cycle n+1+G. Both-off is also expected in cycle n+G, one cycle before the turn-on, so an early switch-on is caught. For a reversal driven in cycle m, the turn-on is due in cycle m+1+G' with the new setting G'. The old turn-on cycle is checked as still off. The driver enqueues each expected level tagged with its absolute cycle number, and the monitor compares it only in that cycle, on the falling clock edge. `clamp_active` is combinational and is checked one nanosecond after the settings are driven.

// File: rtl/dtgap_pkg.sv
package dtgap_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    // Direction index for the two gap settings.
    localparam int DIR_TO_HIGH = 0;
    localparam int DIR_TO_LOW  = 1;
    localparam int DIR_COUNT   = 2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic gate_t phase_to_gate(input phase_e ph);
        gate_t g;
        g.hs = (ph == PH_HIGH);
        g.ls = (ph == PH_LOW);
        return g;
    endfunction

endpackage

// File: rtl/dtgap_limit.sv
module dtgap_limit #(
    parameter int W  = 8,
    parameter int LO = 2,
    parameter int HI = 40
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff,
    output logic         limited
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (raw < LO_V) begin
            eff     = LO_V;
            limited = 1'b1;
        end else if (raw > HI_V) begin
            eff     = HI_V;
            limited = 1'b1;
        end else begin
            eff     = raw;
            limited = 1'b0;
        end
    end
endmodule

// File: rtl/dtgap_sequencer.sv
module dtgap_sequencer
    import dtgap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd,
    input  logic [W-1:0] gap_to_high,
    input  logic [W-1:0] gap_to_low,
    output gate_t        gate
);
    phase_e       ph_q, ph_d;
    logic         tgt_q, tgt_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] load_val;

    // Gap length G yields G both-off cycles: load G-1, leave at zero.
    assign load_val = (cmd ? gap_to_high : gap_to_low) - W'(1);

    always_comb begin
        ph_d  = ph_q;
        tgt_d = tgt_q;
        cnt_d = cnt_q;
        unique case (ph_q)
            PH_IDLE: begin
                ph_d  = PH_GAP;
                tgt_d = cmd;
                cnt_d = load_val;
            end
            PH_HIGH: begin
                if (!cmd) begin
                    ph_d  = PH_GAP;
                    tgt_d = 1'b0;
                    cnt_d = load_val;
                end
            end
            PH_LOW: begin
                if (cmd) begin
                    ph_d  = PH_GAP;
                    tgt_d = 1'b1;
                    cnt_d = load_val;
                end
            end
            PH_GAP: begin
                if (cmd != tgt_q) begin
                    tgt_d = cmd;
                    cnt_d = load_val;
                end else if (cnt_q == '0) begin
                    ph_d = tgt_q ? PH_HIGH : PH_LOW;
                end else begin
                    cnt_d = cnt_q - W'(1);
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            tgt_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            tgt_q <= tgt_d;
            cnt_q <= cnt_d;
        end
    end

    assign gate = phase_to_gate(ph_q);
endmodule

// File: rtl/dtgap_inserter.sv
module dtgap_inserter
    import dtgap_pkg::*;
#(
    parameter int CFG_W = 8,
    parameter int DT_LO = 2,
    parameter int DT_HI = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_cmd,
    input  logic [CFG_W-1:0] dt_lh_cfg,
    input  logic [CFG_W-1:0] dt_hl_cfg,
    output logic             hs_gate,
    output logic             ls_gate,
    output logic             clamp_active
);
    // A floor of at least one tick keeps a zero setting from meaning "no gap".
    localparam int LO_EFF = imax(DT_LO, 1);
    localparam int HI_EFF = imin(imax(DT_HI, LO_EFF), (1 << CFG_W) - 1);

    logic [CFG_W-1:0] raw_set [DIR_COUNT];
    logic [CFG_W-1:0] eff_set [DIR_COUNT];
    logic [DIR_COUNT-1:0] lim_vec;
    gate_t            gate;

    assign raw_set[DIR_TO_HIGH] = dt_lh_cfg;
    assign raw_set[DIR_TO_LOW]  = dt_hl_cfg;

    for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
        dtgap_limit #(
            .W (CFG_W),
            .LO(LO_EFF),
            .HI(HI_EFF)
        ) limit_i (
            .raw    (raw_set[d]),
            .eff    (eff_set[d]),
            .limited(lim_vec[d])
        );
    end

    dtgap_sequencer #(
        .W(CFG_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .cmd        (pwm_cmd),
        .gap_to_high(eff_set[DIR_TO_HIGH]),
        .gap_to_low (eff_set[DIR_TO_LOW]),
        .gate       (gate)
    );

    assign hs_gate      = gate.hs;
    assign ls_gate      = gate.ls;
    assign clamp_active = |lim_vec;
endmodule

// File: rtl/dtgap_inserter_chk.sv
module dtgap_inserter_chk #(
    parameter int CFG_W = 8,
    parameter int DT_LO = 2,
    parameter int DT_HI = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_cmd,
    input logic [CFG_W-1:0] dt_lh_cfg,
    input logic [CFG_W-1:0] dt_hl_cfg,
    input logic             hs_gate,
    input logic             ls_gate,
    input logic             clamp_active
);
    localparam int LO_E = (DT_LO < 1) ? 1 : DT_LO;
    localparam int HI_E = (DT_HI < LO_E) ? LO_E : DT_HI;

    // Run length of both-off cycles, saturating.
    logic [15:0] off_run;
    always_ff @(posedge clk) begin
        if (rst) off_run <= '0;
        else if (hs_gate || ls_gate) off_run <= '0;
        else if (off_run != 16'hFFFF) off_run <= off_run + 16'd1;
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

    assert_hs_drop_on_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_gate) |-> $past(!pwm_cmd));

    assert_gap_floor_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run >= 16'(LO_E)));

    assert_gap_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run <= 16'(HI_E) + 16'd1));

    assert_zero_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (dt_lh_cfg == '0 || dt_hl_cfg == '0) |-> clamp_active);

    assert_reset_off_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hs_gate && !ls_gate));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (hs_gate && pwm_cmd) |=> hs_gate);
endmodule

bind dtgap_inserter dtgap_inserter_chk #(
    .CFG_W(CFG_W),
    .DT_LO(DT_LO),
    .DT_HI(DT_HI)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .pwm_cmd     (pwm_cmd),
    .dt_lh_cfg   (dt_lh_cfg),
    .dt_hl_cfg   (dt_hl_cfg),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .clamp_active(clamp_active)
);

// File: tb/dtgap_inserter_tb_top.sv
module dtgap_inserter_tb_top;
    localparam int CFG_W = 8;
    localparam int LO    = 2;
    localparam int HI    = 40;

    typedef struct {
        int    at;
        bit    hs;
        bit    ls;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwm_cmd = 1'b0;
    logic [CFG_W-1:0] dt_lh_cfg = 8'd6;
    logic [CFG_W-1:0] dt_hl_cfg = 8'd4;
    logic             hs_gate, ls_gate, clamp_active;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   overlap_seen = 1'b0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dtgap_inserter #(.CFG_W(CFG_W), .DT_LO(LO), .DT_HI(HI)) dut_i (
        .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd),
        .dt_lh_cfg(dt_lh_cfg), .dt_hl_cfg(dt_hl_cfg),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .clamp_active(clamp_active)
    );

    function automatic int lim(input int s);
        if (s < LO) return LO;
        if (s > HI) return HI;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input bit hs, input bit ls, input string req);
        exp_t e;
        e.at = at; e.hs = hs; e.ls = ls; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare each expected item in its own cycle.
    always @(negedge clk) begin
        if (!rst && hs_gate && ls_gate) overlap_seen = 1'b1;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.at < cyc)
                check(1'b0, {e.req, " missed slot"}, cyc, e.at);
            else
                check(hs_gate == e.hs && ls_gate == e.ls, e.req,
                      {hs_gate, ls_gate}, {e.hs, e.ls});
        end
    end

    // Drive a new command level and enqueue the expected outputs.
    task automatic go(input bit lvl, input string req);
        int n, g;
        @(negedge clk);
        n = cyc;
        g = lim(lvl ? int'(dt_lh_cfg) : int'(dt_hl_cfg));
        pwm_cmd = lvl;
        push(n + 1, 1'b0, 1'b0, req);
        push(n + g, 1'b0, 1'b0, req);
        push(n + g + 1, lvl, !lvl, req);
        push(n + g + 3, lvl, !lvl, {req, " hold R10"});
        repeat (g + 4) @(negedge clk);
    endtask

    task automatic set_cfg(input int lh, input int hl, input bit exp_clamp, input string req);
        @(negedge clk);
        dt_lh_cfg = CFG_W'(lh);
        dt_hl_cfg = CFG_W'(hl);
        #1;
        check(clamp_active == exp_clamp, req, clamp_active, exp_clamp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!hs_gate && !ls_gate, "R7 reset both off", {hs_gate, ls_gate}, 0);
        // R7: release reset with command low; low side waits its full gap (4).
        @(negedge clk);
        n = cyc;
        rst = 1'b0;
        push(n + 1, 0, 0, "R7");
        push(n + 4, 0, 0, "R7");
        push(n + 5, 0, 1, "R7");
        repeat (8) @(negedge clk);

        check(clamp_active == 1'b0, "R6 in range", clamp_active, 0);
        go(1'b1, "R2/R3 to high gap 6");
        go(1'b0, "R2/R3 to low gap 4");

        // R4: monotonic one-tick steps.
        set_cfg(3, 4, 1'b0, "R6 in range");
        go(1'b1, "R4 gap 3");
        go(1'b0, "R4 low");
        set_cfg(4, 4, 1'b0, "R6 in range");
        go(1'b1, "R4 gap 4");

        // R5/R6: zero and below floor, above ceiling, no wrap.
        set_cfg(4, 0, 1'b1, "R6 zero flags");
        go(1'b0, "R5 zero gives floor");
        set_cfg(1, 0, 1'b1, "R6 low flags");
        go(1'b1, "R5 one gives floor");
        set_cfg(200, 255, 1'b1, "R6 high flags");
        go(1'b0, "R5 255 gives ceiling");
        go(1'b1, "R5 200 gives ceiling");

        // R8: setting changed mid-gap is ignored for that gap.
        set_cfg(7, 5, 1'b0, "R6 in range");
        @(negedge clk);
        n = cyc;
        pwm_cmd = 1'b0;
        push(n + 5, 0, 0, "R8");
        push(n + 6, 0, 1, "R8");
        repeat (2) @(negedge clk);
        dt_hl_cfg = 8'd20;
        repeat (10) @(negedge clk);

        // R9: reversal during gap restarts with new direction.
        dt_hl_cfg = 8'd6;
        go(1'b1, "R9 setup");
        @(negedge clk);
        n = cyc;
        pwm_cmd = 1'b0;
        push(n + 1, 0, 0, "R9");
        repeat (3) @(negedge clk);
        pwm_cmd = 1'b1;
        push(n + 7, 0, 0, "R9 old slot stays off");
        push(n + 10, 0, 0, "R9");
        push(n + 11, 1, 0, "R9 restart gap 7");
        repeat (14) @(negedge clk);

        check(!overlap_seen, "R1 no overlap", overlap_seen, 0);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule